// File: doc/BRIEF.md
# SDRAM Command Decoder

This block watches the command and address pins of a synchronous DRAM interface and names the command presented at each rising clock edge. The pin combination sets the command. Every edge counts as one sample, and a deasserted chip select turns the sample into an idle cycle whatever the other pins carry.

For each sample the block produces a registered record one clock later. The record holds an opcode, a valid strobe, the bank the command addresses as a number and as a one-hot mask, a flag for the self-closing form of a column access, a flag for a close of every bank, and a copy of the address pins. Bank state machines further down read this record instead of decoding the raw pins themselves. The block does not check timing between commands. It applies no effect of the mode-load or refresh commands and only names them.

Top module: `sdram_cmd_decode`

## Requirements
- R1: While rst_n is low, every output is zero, and cmd_op is 0 (idle).
- R2: The record for a sample taken at a rising edge appears at the outputs after that edge and holds until the next rising edge. Before the edge, the outputs still show the previous record.
- R3: With cs_n low, {ras_n,cas_n,we_n} gives cmd_op as follows: 111 gives 0 (idle), 011 gives 1 (activate), 101 gives 2 (read), 100 gives 3 (write), 010 gives 4 (precharge), 110 gives 5 (burst stop), 001 gives 6 (refresh) and 000 gives 7 (mode load).
- R4: With cs_n high, the record is idle: cmd_op 0, with valid, bank, mask, both flags and cmd_addr all zero.
- R5: cmd_valid is high exactly when cmd_op is non-zero. An idle record carries cmd_addr zero, and any valid record carries the sampled address pins on cmd_addr.
- R6: cmd_auto_pre equals address bit 10 on a read or a write, and is zero for every other opcode.
- R7: On activate, read and write, cmd_bank equals the bank pins, and cmd_bank_mask has exactly the bit of that bank set.
- R8: On a precharge with address bit 10 low, bank pins 0 to 3 set cmd_bank to that value and set mask bit 0 to 3 respectively, with cmd_all_banks low.
- R9: On a precharge with address bit 10 high, cmd_all_banks is high, the mask is all ones and cmd_bank is zero, whatever the bank pins carry.
- R10: On burst stop, refresh, mode load and idle records, cmd_bank, the mask and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank | input | BANK_W (2) | Bank select pins |
| addr | input | ADDR_W (13) | Address pins. Bit AP_BIT (10) is the close flag |
| cmd_valid | output | 1 | High for any non-idle record |
| cmd_op | output | 3 | Opcode, encoded as in R3 |
| cmd_bank | output | BANK_W (2) | Addressed bank number |
| cmd_bank_mask | output | 2**BANK_W (4) | One-hot bank mask, or all ones for a close of every bank |
| cmd_auto_pre | output | 1 | Self-closing read or write |
| cmd_all_banks | output | 1 | Precharge applies to every bank |
| cmd_addr | output | ADDR_W (13) | Sampled address of a valid record |

## Verification
Each record is due exactly one rising edge after its sample, so the bench drives the pins on a falling edge and compares the whole record on the next falling edge. By then exactly one register stage has loaded. The latency scenario also reads the outputs just after it drives the pins and before the rising edge, to confirm that the old record is still there. It then checks the following falling edge to confirm that a one-cycle command leaves after one cycle. The checker's properties use $past with a depth of one, which matches this single register stage.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ACT = 3'd1,
        OP_RD  = 3'd2,
        OP_WR  = 3'd3,
        OP_PRE = 3'd4,
        OP_BST = 3'd5,
        OP_REF = 3'd6,
        OP_MRS = 3'd7
    } cmd_op_e;

    // Commands that address exactly one bank through the bank pins.
    function automatic logic op_hits_one_bank(input cmd_op_e op);
        return (op == OP_ACT) || (op == OP_RD) || (op == OP_WR);
    endfunction

    // Column accesses, which carry the self-closing flag.
    function automatic logic op_is_column(input cmd_op_e op);
        return (op == OP_RD) || (op == OP_WR);
    endfunction

endpackage

// File: rtl/sdram_pin_classify.sv
module sdram_pin_classify
    import sdram_cmd_pkg::*;
(
    input  logic    cs_n,
    input  logic    ras_n,
    input  logic    cas_n,
    input  logic    we_n,
    output cmd_op_e op
);

    always_comb begin
        if (cs_n) begin
            op = OP_NOP;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111: op = OP_NOP;
                3'b011: op = OP_ACT;
                3'b101: op = OP_RD;
                3'b100: op = OP_WR;
                3'b010: op = OP_PRE;
                3'b110: op = OP_BST;
                3'b001: op = OP_REF;
                3'b000: op = OP_MRS;
                default: op = OP_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdram_bank_select.sv
module sdram_bank_select
    import sdram_cmd_pkg::*;
#(
    parameter  int BANK_W    = 2,
    localparam int NUM_BANKS = 1 << BANK_W
) (
    input  cmd_op_e               op,
    input  logic [BANK_W-1:0]    bank_pins,
    input  logic                  a10,
    output logic [BANK_W-1:0]    bank_o,
    output logic [NUM_BANKS-1:0] mask_o,
    output logic                  all_o,
    output logic                  auto_pre_o
);

    logic [NUM_BANKS-1:0] single_mask;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank_hit
        assign single_mask[g] = (bank_pins == BANK_W'(g));
    end

    always_comb begin
        bank_o     = '0;
        mask_o     = '0;
        all_o      = 1'b0;
        auto_pre_o = 1'b0;
        if (op_hits_one_bank(op)) begin
            bank_o     = bank_pins;
            mask_o     = single_mask;
            auto_pre_o = op_is_column(op) & a10;
        end else if (op == OP_PRE) begin
            if (a10) begin
                all_o  = 1'b1;
                mask_o = '1;
            end else begin
                bank_o = bank_pins;
                mask_o = single_mask;
            end
        end
    end

endmodule

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_cmd_pkg::*;
#(
    parameter  int ADDR_W    = 13,
    parameter  int BANK_W    = 2,
    parameter  int AP_BIT    = 10,
    localparam int NUM_BANKS = 1 << BANK_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  ras_n,
    input  logic                  cas_n,
    input  logic                  we_n,
    input  logic [BANK_W-1:0]    bank,
    input  logic [ADDR_W-1:0]    addr,
    output logic                  cmd_valid,
    output logic [2:0]            cmd_op,
    output logic [BANK_W-1:0]    cmd_bank,
    output logic [NUM_BANKS-1:0] cmd_bank_mask,
    output logic                  cmd_auto_pre,
    output logic                  cmd_all_banks,
    output logic [ADDR_W-1:0]    cmd_addr
);

    typedef struct packed {
        logic                 valid;
        cmd_op_e              op;
        logic [BANK_W-1:0]    bank;
        logic [NUM_BANKS-1:0] mask;
        logic                 auto_pre;
        logic                 all_banks;
        logic [ADDR_W-1:0]    addr;
    } rec_t;

    rec_t rec_d, rec_q;

    cmd_op_e              raw_op;
    logic [BANK_W-1:0]    sel_bank;
    logic [NUM_BANKS-1:0] sel_mask;
    logic                 sel_all;
    logic                 sel_ap;

    sdram_pin_classify i_classify (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .op    (raw_op)
    );

    sdram_bank_select #(.BANK_W(BANK_W)) i_bank_sel (
        .op         (raw_op),
        .bank_pins  (bank),
        .a10        (addr[AP_BIT]),
        .bank_o     (sel_bank),
        .mask_o     (sel_mask),
        .all_o      (sel_all),
        .auto_pre_o (sel_ap)
    );

    always_comb begin
        rec_d           = '0;
        rec_d.op        = raw_op;
        rec_d.valid     = (raw_op != OP_NOP);
        rec_d.bank      = sel_bank;
        rec_d.mask      = sel_mask;
        rec_d.auto_pre  = sel_ap;
        rec_d.all_banks = sel_all;
        rec_d.addr      = rec_d.valid ? addr : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_q <= '0;
        end else begin
            rec_q <= rec_d;
        end
    end

    assign cmd_valid     = rec_q.valid;
    assign cmd_op        = rec_q.op;
    assign cmd_bank      = rec_q.bank;
    assign cmd_bank_mask = rec_q.mask;
    assign cmd_auto_pre  = rec_q.auto_pre;
    assign cmd_all_banks = rec_q.all_banks;
    assign cmd_addr      = rec_q.addr;

endmodule

// File: rtl/sdram_cmd_decode_chk.sv
module sdram_cmd_decode_chk
    import sdram_cmd_pkg::*;
#(
    parameter  int ADDR_W    = 13,
    parameter  int BANK_W    = 2,
    parameter  int AP_BIT    = 10,
    localparam int NUM_BANKS = 1 << BANK_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cs_n,
    input logic                  ras_n,
    input logic                  cas_n,
    input logic                  we_n,
    input logic [ADDR_W-1:0]    addr,
    input logic                  cmd_valid,
    input logic [2:0]            cmd_op,
    input logic [BANK_W-1:0]    cmd_bank,
    input logic [NUM_BANKS-1:0] cmd_bank_mask,
    input logic                  cmd_auto_pre,
    input logic                  cmd_all_banks
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(cs_n) |-> !cmd_valid && (cmd_bank_mask == '0)); // R4

    AST_ACT_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(!cs_n && !ras_n && cas_n && we_n) |-> cmd_op == OP_ACT); // R3

    AST_VALID_NONIDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_op != OP_NOP); // R5

    AST_IDLE_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_op == OP_NOP |-> !cmd_valid); // R5

    AST_AP_COLUMN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_auto_pre |-> (cmd_op == OP_RD) || (cmd_op == OP_WR)); // R6

    AST_AP_FROM_A10: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(!cs_n && ras_n && !cas_n) |-> cmd_auto_pre == $past(addr[AP_BIT])); // R6

    AST_TARGET_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_ACT) || (cmd_op == OP_RD) || (cmd_op == OP_WR)
        |-> ($countones(cmd_bank_mask) == 1) && cmd_bank_mask[cmd_bank]); // R7

    AST_ALL_BANKS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_all_banks |-> (cmd_op == OP_PRE) && (&cmd_bank_mask) && (cmd_bank == '0)); // R9

    AST_NO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_BST) || (cmd_op == OP_REF) || (cmd_op == OP_MRS) || (cmd_op == OP_NOP)
        |-> (cmd_bank_mask == '0) && !cmd_auto_pre && !cmd_all_banks && (cmd_bank == '0)); // R10

endmodule

bind sdram_cmd_decode sdram_cmd_decode_chk #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W),
    .AP_BIT (AP_BIT)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs_n          (cs_n),
    .ras_n         (ras_n),
    .cas_n         (cas_n),
    .we_n          (we_n),
    .addr          (addr),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .cmd_bank      (cmd_bank),
    .cmd_bank_mask (cmd_bank_mask),
    .cmd_auto_pre  (cmd_auto_pre),
    .cmd_all_banks (cmd_all_banks)
);

// File: tb/test_sdram_cmd_decode.sv
module test_sdram_cmd_decode;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 13;
    localparam int BANK_W     = 2;
    localparam int NB         = 1 << BANK_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [BANK_W-1:0] bank = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic              cmd_valid, cmd_auto_pre, cmd_all_banks;
    logic [2:0]        cmd_op;
    logic [BANK_W-1:0] cmd_bank;
    logic [NB-1:0]     cmd_bank_mask;
    logic [ADDR_W-1:0] cmd_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cmd_decode i_sdram_cmd_decode (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .bank(bank), .addr(addr), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_bank_mask(cmd_bank_mask), .cmd_auto_pre(cmd_auto_pre),
        .cmd_all_banks(cmd_all_banks), .cmd_addr(cmd_addr)
    );

    task automatic expect_rec(input string req, input logic v, input logic [2:0] op,
                              input logic [BANK_W-1:0] b, input logic [NB-1:0] m,
                              input logic ap, input logic all, input logic [ADDR_W-1:0] a);
        logic [24:0] got, exp;
        got = {cmd_valid, cmd_op, cmd_bank, cmd_bank_mask, cmd_auto_pre, cmd_all_banks, cmd_addr};
        exp = {v, op, b, m, ap, all, a};
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got v=%b op=%0d bank=%0d mask=%b ap=%b all=%b addr=%h, expected v=%b op=%0d bank=%0d mask=%b ap=%b all=%b addr=%h",
                     req, got[24], got[23:21], got[20:19], got[18:15], got[14], got[13], got[12:0],
                     v, op, b, m, ap, all, a);
        end
    endtask

    // Drive pins on a falling edge; the record is checked on the next falling edge.
    task automatic drive(input logic c, input logic r, input logic ca, input logic w,
                         input logic [BANK_W-1:0] b, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        cs_n = c; ras_n = r; cas_n = ca; we_n = w; bank = b; addr = a;
    endtask

    task automatic idle_pins();
        drive(1'b0, 1'b1, 1'b1, 1'b1, '0, '0);
    endtask

    task automatic t_reset();
        #1;
        expect_rec("R1", 0, 3'd0, '0, '0, 0, 0, '0);
        cs_n = 1'b0; ras_n = 1'b0; cas_n = 1'b1; we_n = 1'b1; addr = 13'h1abc;
        repeat (2) @(negedge clk);
        expect_rec("R1", 0, 3'd0, '0, '0, 0, 0, '0);
        cs_n = 1'b1; ras_n = 1'b1; addr = '0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_latency();
        drive(1'b0, 1'b0, 1'b1, 1'b1, 2'd2, 13'h0123);
        #1;
        expect_rec("R2", 0, 3'd0, '0, '0, 0, 0, '0);
        idle_pins();
        expect_rec("R2", 1, 3'd1, 2'd2, 4'b0100, 0, 0, 13'h0123);
        @(negedge clk);
        expect_rec("R2", 0, 3'd0, '0, '0, 0, 0, '0);
    endtask

    task automatic t_activate();
        for (int b = 0; b < NB; b++) begin
            drive(1'b0, 1'b0, 1'b1, 1'b1, BANK_W'(b), 13'h0400 + 13'(b));
            @(negedge clk);
            expect_rec("R7", 1, 3'd1, BANK_W'(b), NB'(1) << b, 0, 0, 13'h0400 + 13'(b));
        end
    endtask

    task automatic t_column();
        drive(1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 13'h0010);
        @(negedge clk);
        expect_rec("R6 read plain", 1, 3'd2, 2'd1, 4'b0010, 0, 0, 13'h0010);
        drive(1'b0, 1'b1, 1'b0, 1'b1, 2'd3, 13'h0410);
        @(negedge clk);
        expect_rec("R6 read auto", 1, 3'd2, 2'd3, 4'b1000, 1, 0, 13'h0410);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 13'h0022);
        @(negedge clk);
        expect_rec("R3 write plain", 1, 3'd3, 2'd0, 4'b0001, 0, 0, 13'h0022);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 13'h1422);
        @(negedge clk);
        expect_rec("R6 write auto", 1, 3'd3, 2'd2, 4'b0100, 1, 0, 13'h1422);
    endtask

    task automatic t_precharge();
        for (int b = 0; b < NB; b++) begin
            drive(1'b0, 1'b0, 1'b1, 1'b0, BANK_W'(b), 13'h0000);
            @(negedge clk);
            expect_rec("R8", 1, 3'd4, BANK_W'(b), NB'(1) << b, 0, 0, 13'h0000);
        end
        drive(1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 13'h0400);
        @(negedge clk);
        expect_rec("R9", 1, 3'd4, 2'd0, 4'b1111, 0, 1, 13'h0400);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 13'h0401);
        @(negedge clk);
        expect_rec("R9", 1, 3'd4, 2'd0, 4'b1111, 0, 1, 13'h0401);
    endtask

    task automatic t_deselect();
        drive(1'b1, 1'b0, 1'b1, 1'b1, 2'd3, 13'h1fff);
        @(negedge clk);
        expect_rec("R4 activate pins", 0, 3'd0, '0, '0, 0, 0, '0);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 13'h0400);
        @(negedge clk);
        expect_rec("R4 read pins", 0, 3'd0, '0, '0, 0, 0, '0);
    endtask

    task automatic t_other_ops();
        drive(1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 13'h0400);
        @(negedge clk);
        expect_rec("R10 burst stop", 1, 3'd5, '0, '0, 0, 0, 13'h0400);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 13'h0400);
        @(negedge clk);
        expect_rec("R10 refresh", 1, 3'd6, '0, '0, 0, 0, 13'h0400);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 13'h0432);
        @(negedge clk);
        expect_rec("R3 mode load", 1, 3'd7, '0, '0, 0, 0, 13'h0432);
        drive(1'b0, 1'b1, 1'b1, 1'b1, 2'd3, 13'h0555);
        @(negedge clk);
        expect_rec("R5 idle", 0, 3'd0, '0, '0, 0, 0, '0);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_activate();
        t_column();
        t_precharge();
        t_deselect();
        t_other_ops();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got no completion, expected end of scenarios");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule